// File: doc/BRIEF.md
# Character Display Position-to-Address Mapper with Circular Shift

This block sits between the scan logic of a character display controller and its 80-entry character RAM. For each visible cell, the scan logic presents a line selector and a column number. The block returns the RAM address whose character code belongs at that cell. It also holds a horizontal shift offset, and shift-left, shift-right and home commands change that offset. Scrolling therefore moves the whole visible text and never rewrites the RAM.

The block has two layouts. In one-line mode the 80 addresses form a single ring, starting at address 0. In two-line mode the first line uses a region of LINE_LEN addresses starting at 0. The second line uses an equally sized region starting at LINE2_BASE, so its addresses do not follow on from the end of the first line. In two-line mode a shift rotates each line inside its own region. The visible window, normally 20 cells, is a matter for the caller. Any column inside the line length maps to an address.

Top module: `lcd_pos_mapper`

## Requirements
- R1: After reset the offset is 0 and the layout is one-line, so the address equals the column for every column below 80.
- R2: In one-line mode the address is (column + offset) mod 80, and the line selector has no effect on it.
- R3: In two-line mode, with line selector 0, the address is (column + offset) mod 40, which lies in 0x00–0x27.
- R4: In two-line mode, with line selector 1, the address is 0x40 + (column + offset) mod 40, which lies in 0x40–0x67.
- R5: A clock edge with only the shift-left command raised increments the offset by one. The offset wraps to 0 after 79 in one-line mode and after 39 in two-line mode.
- R6: A clock edge with only the shift-right command raised decrements the offset by one. The offset wraps from 0 to 79 in one-line mode and to 39 in two-line mode.
- R7: A clock edge with home raised clears the offset to 0. Home takes precedence over any shift command raised in the same cycle.
- R8: A clock edge with both shift commands raised and home low leaves the offset unchanged.
- R9: The layout input (0 = one-line, 1 = two-line) takes effect at a clock edge. An edge at which it differs from the current layout switches the layout and clears the offset, and any shift or home command raised in that cycle has no effect.
- R10: The column-valid output is 1 exactly when the column is below the current line length: 80 in one-line mode, 40 in two-line mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| two_line_i | input | 1 | Requested layout: 0 one-line, 1 two-line |
| shift_left_i | input | 1 | Increment the shift offset at the next edge |
| shift_right_i | input | 1 | Decrement the shift offset at the next edge |
| home_i | input | 1 | Clear the shift offset at the next edge |
| line_sel_i | input | 1 | Requested line: 0 first, 1 second (two-line mode only) |
| col_i | input | 7 | Requested column |
| col_ok_o | output | 1 | Column lies inside the current line length |
| ram_addr_o | output | 7 | Character RAM address for the requested cell |

## Verification
The bench builds the block with its defaults: LINE_LEN 40 and LINE2_BASE 0x40. These values give both wrap points, 79 to 0 in the single ring and 39 to 0 in each half. Both are reached by stepping the offset through more than a full lap in each layout. Column values run past 80 so that the valid flag is exercised at both boundaries. Layout toggles are mixed with shift and home commands, which checks the clearing and precedence rules on the edges where they collide.

// File: rtl/lcdmap_pkg.sv
package lcdmap_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_HOME = 2'd1,
    OP_INC  = 2'd2,
    OP_DEC  = 2'd3
  } shift_op_e;

  function automatic shift_op_e decode_op(input logic home,
                                          input logic left,
                                          input logic right);
    if (home)
      return OP_HOME;
    else if (left && !right)
      return OP_INC;
    else if (right && !left)
      return OP_DEC;
    else
      return OP_HOLD;
  endfunction

endpackage

// File: rtl/lcdmap_shift_ctl.sv
module lcdmap_shift_ctl
  import lcdmap_pkg::*;
#(
  parameter int LINE_LEN = 40,
  parameter int OFF_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             two_line_i,
  input  logic             shift_left_i,
  input  logic             shift_right_i,
  input  logic             home_i,
  output logic             two_line_q_o,
  output logic [OFF_W-1:0] offset_o
);

  localparam logic [OFF_W-1:0] LAST_ONE = OFF_W'(2*LINE_LEN - 1);
  localparam logic [OFF_W-1:0] LAST_TWO = OFF_W'(LINE_LEN - 1);

  logic             mode_q, mode_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic [OFF_W-1:0] last;
  logic             mode_chg;
  shift_op_e        op;

  always_comb begin
    last     = mode_q ? LAST_TWO : LAST_ONE;
    mode_chg = (two_line_i != mode_q);
    op       = decode_op(home_i, shift_left_i, shift_right_i);
    mode_d   = mode_q;
    off_d    = off_q;
    if (mode_chg) begin
      mode_d = two_line_i;
      off_d  = '0;
    end else begin
      unique case (op)
        OP_HOME: off_d = '0;
        OP_INC:  off_d = (off_q == last) ? '0 : off_q + 1'b1;
        OP_DEC:  off_d = (off_q == '0) ? last : off_q - 1'b1;
        default: off_d = off_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      off_q  <= '0;
    end else begin
      mode_q <= mode_d;
      off_q  <= off_d;
    end
  end

  assign two_line_q_o = mode_q;
  assign offset_o     = off_q;

  // R5
  off_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_q <= (mode_q ? LAST_TWO : LAST_ONE));

  // R7
  home_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (home_i && two_line_i == mode_q) |=> (off_q == '0));

  // R9
  mode_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (two_line_i != mode_q) |=> (off_q == '0 && mode_q == $past(two_line_i)));

  // R8
  both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_left_i && shift_right_i && !home_i && two_line_i == mode_q)
    |=> $stable(off_q));

  // R6
  dec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_right_i && !shift_left_i && !home_i && two_line_i == mode_q && off_q == '0)
    |=> (off_q == (mode_q ? LAST_TWO : LAST_ONE)));

endmodule

// File: rtl/lcdmap_addr_calc.sv
module lcdmap_addr_calc #(
  parameter int LINE_LEN   = 40,
  parameter int LINE2_BASE = 64,
  parameter int COL_W      = 7,
  parameter int ADDR_W     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              two_line_q_i,
  input  logic              line_sel_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [COL_W-1:0]  offset_i,
  output logic              col_ok_o,
  output logic [ADDR_W-1:0] addr_o
);

  localparam logic [COL_W:0]    LEN_ONE = (COL_W+1)'(2*LINE_LEN);
  localparam logic [COL_W:0]    LEN_TWO = (COL_W+1)'(LINE_LEN);
  localparam logic [ADDR_W-1:0] BASE2   = ADDR_W'(LINE2_BASE);

  logic [COL_W:0]    len;
  logic [COL_W:0]    sum;
  logic [COL_W:0]    wrapped;
  logic [ADDR_W-1:0] base;

  always_comb begin
    len      = two_line_q_i ? LEN_TWO : LEN_ONE;
    sum      = {1'b0, col_i} + {1'b0, offset_i};
    wrapped  = (sum >= len) ? (sum - len) : sum;
    base     = (two_line_q_i && line_sel_i) ? BASE2 : '0;
    col_ok_o = ({1'b0, col_i} < len);
    addr_o   = base + ADDR_W'(wrapped);
  end

  // R2
  one_line_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_ok_o && !two_line_q_i) |-> (addr_o < ADDR_W'(2*LINE_LEN)));

  // R3
  line1_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_ok_o && two_line_q_i && !line_sel_i) |-> (addr_o < ADDR_W'(LINE_LEN)));

  // R4
  line2_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_ok_o && two_line_q_i && line_sel_i)
    |-> (addr_o >= BASE2 && addr_o < ADDR_W'(LINE2_BASE + LINE_LEN)));

endmodule

// File: rtl/lcd_pos_mapper.sv
module lcd_pos_mapper #(
  parameter int LINE_LEN   = 40,
  parameter int LINE2_BASE = 64,
  parameter int COL_W      = $clog2(2*LINE_LEN),
  parameter int ADDR_W     = $clog2(LINE2_BASE + LINE_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              two_line_i,
  input  logic              shift_left_i,
  input  logic              shift_right_i,
  input  logic              home_i,
  input  logic              line_sel_i,
  input  logic [COL_W-1:0]  col_i,
  output logic              col_ok_o,
  output logic [ADDR_W-1:0] ram_addr_o
);

  logic             two_line_q;
  logic [COL_W-1:0] offset;

  lcdmap_shift_ctl #(
    .LINE_LEN (LINE_LEN),
    .OFF_W    (COL_W)
  ) u_shift (
    .clk           (clk),
    .rst_n         (rst_n),
    .two_line_i    (two_line_i),
    .shift_left_i  (shift_left_i),
    .shift_right_i (shift_right_i),
    .home_i        (home_i),
    .two_line_q_o  (two_line_q),
    .offset_o      (offset)
  );

  lcdmap_addr_calc #(
    .LINE_LEN   (LINE_LEN),
    .LINE2_BASE (LINE2_BASE),
    .COL_W      (COL_W),
    .ADDR_W     (ADDR_W)
  ) u_addr (
    .clk          (clk),
    .rst_n        (rst_n),
    .two_line_q_i (two_line_q),
    .line_sel_i   (line_sel_i),
    .col_i        (col_i),
    .offset_i     (offset),
    .col_ok_o     (col_ok_o),
    .addr_o       (ram_addr_o)
  );

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!two_line_q && offset == '0));

endmodule

// File: tb/lcd_pos_mapper_bench.sv
module lcd_pos_mapper_bench;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       two_line = 1'b0;
  logic       sl = 1'b0;
  logic       sr = 1'b0;
  logic       home = 1'b0;
  logic       line_sel = 1'b0;
  logic [6:0] col = '0;
  logic       col_ok;
  logic [6:0] addr;

  int n_vec = 0;
  int n_bad = 0;
  int m_two = 0;
  int m_off = 0;
  int cycles = 0;

  always #(CLK_P/2) clk = ~clk;

  lcd_pos_mapper u_lcd_pos_mapper (
    .clk           (clk),
    .rst_n         (rst_n),
    .two_line_i    (two_line),
    .shift_left_i  (sl),
    .shift_right_i (sr),
    .home_i        (home),
    .line_sel_i    (line_sel),
    .col_i         (col),
    .col_ok_o      (col_ok),
    .ram_addr_o    (addr)
  );

  // behavioural reference of the offset and layout
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_two = 0;
      m_off = 0;
    end else begin
      int len;
      len = (m_two != 0) ? 40 : 80;
      if (int'(two_line) != m_two) begin
        m_two = int'(two_line);
        m_off = 0;
      end else if (home) m_off = 0;
      else if (sl && !sr) m_off = (m_off + 1) % len;
      else if (sr && !sl) m_off = (m_off + len - 1) % len;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic step(input logic t, input logic l, input logic r, input logic h,
                      input logic ls, input int c, input string tag);
    int len;
    int exp_addr;
    bit exp_ok;
    string rq;
    @(negedge clk);
    two_line = t; sl = l; sr = r; home = h; line_sel = ls; col = 7'(c);
    #1;
    len      = (m_two != 0) ? 40 : 80;
    exp_ok   = (c < len);
    exp_addr = ((m_two != 0 && ls) ? 64 : 0) + ((c + m_off) % len);
    if (tag != "") rq = tag;
    else if (!exp_ok) rq = "R10";
    else if (m_two == 0) rq = "R2";
    else if (ls) rq = "R4";
    else rq = "R3";
    n_vec++;
    if (col_ok !== exp_ok) begin
      n_bad++;
      $display("FAIL %s col_ok col=%0d: actual %0b expected %0b", rq, c, col_ok, exp_ok);
    end else if (exp_ok && int'(addr) != exp_addr) begin
      n_bad++;
      $display("FAIL %s addr col=%0d line=%0b: actual %0d expected %0d",
               rq, c, ls, addr, exp_addr);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: fresh state, line selector irrelevant
    step(0, 0, 0, 0, 0, 5, "R1");
    step(0, 0, 0, 0, 1, 79, "R1");
    // R5: single ring, past the 79 -> 0 wrap
    for (int k = 0; k < 85; k++) step(0, 1, 0, 0, k[0], (k * 7) % 80, "R5");
    // R7: home wins over a shift
    step(0, 1, 0, 1, 0, 10, "R7");
    step(0, 0, 0, 0, 0, 10, "R7");
    // R6: 0 -> 79 wrap
    for (int k = 0; k < 4; k++) step(0, 0, 1, 0, 0, 3 + k, "R6");
    // R8: both shifts
    step(0, 1, 1, 0, 0, 20, "R8");
    step(0, 0, 0, 0, 0, 20, "R8");
    // R10: columns past the single ring
    for (int c = 78; c < 90; c++) step(0, 0, 0, 0, 0, c, "R10");
    // R9: switch to two-line with a shift raised
    step(0, 1, 0, 0, 0, 1, "R9");
    step(1, 1, 0, 0, 0, 2, "R9");
    step(1, 0, 0, 0, 1, 2, "R9");
    // R3 / R4 with the 39 -> 0 wrap
    for (int k = 0; k < 90; k++)
      step(1, 1, 0, 0, k[0], (k * 3) % 40, k[0] ? "R4" : "R3");
    // R10 in two-line
    for (int c = 36; c < 46; c++) step(1, 0, 0, 0, c[0], c, "R10");
    // R6: two-line wrap 0 -> 39
    step(1, 0, 0, 1, 0, 0, "R7");
    for (int k = 0; k < 3; k++) step(1, 0, 1, 0, 1, 39 - k, "R6");
    // R9: back to one-line with home and shift raised
    step(0, 0, 1, 1, 0, 50, "R9");
    step(0, 0, 0, 0, 0, 50, "R9");
    // mixed traffic
    for (int k = 0; k < 3000; k++) begin
      logic t;
      t = ($urandom % 60 == 0) ? ~two_line : two_line;
      step(t, ($urandom % 3) == 0, ($urandom % 4) == 0, ($urandom % 40) == 0,
           1'($urandom), int'($urandom % 90), "");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule